// File: doc/BRIEF.md
# Protected-Mode Segment Register with Descriptor Fetch and Address Translation

This block stands for a single segment register of a protected-mode processor. A load request presents a 16-bit selector together with the current privilege level of the running code. The block rejects impossible selectors at once. For the others it fetches the 8-byte descriptor from a descriptor table in memory, using two 32-bit reads on a valid/ready read port. It then runs the present and privilege checks. A passing descriptor has its base, effective limit and attribute bits cached in a hidden register. A failing one raises a general protection fault and leaves the register as it was.

Once a segment is loaded, data accesses give a 32-bit offset. The block returns the linear address, which is the cached base plus the offset, wrapping at 32 bits. It flags a fault when the offset lies beyond the effective limit or when no segment has been loaded. Translation reads only the cached values and never touches the table again.

Top module: `segreg_xlate`

## Requirements
- R1: The selector splits into index `sel[15:3]`, table indicator `sel[2]` and requested level `sel[1:0]`. Descriptor `i` is read as its low word at `TBL_BASE + 8*i` and then its high word at `TBL_BASE + 8*i + 4`.
- R2: A selector with table indicator 1, index 0, or index `>= TBL_ENTRIES` faults without any read on the memory port.
- R3: A fetched descriptor faults when max(`cpl`, RPL) is greater than its DPL. Both `cpl` and the selector are sampled when the request is accepted.
- R4: A fetched descriptor whose present bit (high word bit 15) is clear faults.
- R5: A fault changes neither `seg_valid`, `seg_sel` nor the cached base and limit. `ld_fault` pulses only together with `ld_done`.
- R6: The descriptor is decoded as follows. The low word carries limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word carries base[23:16] in bits 7:0, the access byte (type, S, DPL at 14:13, P) in bits 15:8, limit[19:16] in bits 19:16, the flag nibble (AVL, L, D, G) in bits 23:20, and base[31:24] in bits 31:24. `seg_attr` reports {flag nibble, access byte}.
- R7: With G (high word bit 23) set, the effective limit is `limit20*4096 + 4095`. With G clear it is `limit20` bytes.
- R8: For an offset no greater than the effective limit, `xl_lin` equals base + offset modulo 2^32 and `xl_fault` stays low.
- R9: `xl_fault` is high while `xl_valid` is high and either the offset exceeds the effective limit or no segment has been loaded.
- R10: `busy` is high from acceptance until completion. Requests made while busy are ignored. `rd_valid` and `rd_addr` hold until `rd_ready`.
- R11: After reset `busy`, `ld_done`, `ld_fault`, `rd_valid` and `seg_valid` are low, and `seg_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load request |
| ld_sel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level of the running code |
| busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse when a load ends |
| ld_fault | output | 1 | Protection fault for the load that ends |
| rd_valid | output | 1 | Table read request |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_addr | output | 32 | Byte address of the table word |
| rd_data | input | 32 | Table word |
| xl_valid | input | 1 | Translation request |
| xl_off | input | 32 | Offset into the segment |
| xl_lin | output | 32 | Linear address |
| xl_fault | output | 1 | Translation fault |
| seg_valid | output | 1 | A segment is loaded |
| seg_sel | output | 16 | Selector currently loaded |
| seg_attr | output | 12 | Cached flag nibble and access byte |

## Verification
The bench builds the block with its defaults: an eight-entry table at 0x1000. This keeps the whole selector space of interest small enough to sweep every combination. The sweep covers table indices 0 to 9 (two past the end), both values of the table indicator, all four requested levels and all four current levels. The table holds ring-0 and ring-3 code and data entries, a byte-granular entry, a not-present entry and a ring-1 entry with a small page-granular limit. This brings every fault source, both granularities, the exact limit edge and 32-bit wrap-around within reach. The read port stalls on a repeating pattern, so the hold rules are exercised on both words.

// File: rtl/segreg_xlate.sv
module segreg_xlate #(
  parameter int unsigned TBL_ENTRIES = 8,
  parameter logic [31:0] TBL_BASE    = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_req,
  input  logic [15:0] ld_sel,
  input  logic [1:0]  cpl,
  output logic        busy,
  output logic        ld_done,
  output logic        ld_fault,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic [31:0] rd_data,
  input  logic        xl_valid,
  input  logic [31:0] xl_off,
  output logic [31:0] xl_lin,
  output logic        xl_fault,
  output logic        seg_valid,
  output logic [15:0] seg_sel,
  output logic [11:0] seg_attr
);
  localparam int IDX_W = 13;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t         st;
  logic [15:0] pend_sel;
  logic [1:0]  pend_cpl;
  logic [31:0] lo_w;
  logic [31:0] c_base, c_lim;

  wire [IDX_W-1:0] req_idx = ld_sel[15:3];
  wire             pre_bad = ld_sel[2] || (req_idx == '0) ||
                             ({{(32-IDX_W){1'b0}}, req_idx} >= TBL_ENTRIES);

  wire [1:0]  pend_rpl = pend_sel[1:0];
  wire [1:0]  eff_pl   = (pend_cpl > pend_rpl) ? pend_cpl : pend_rpl;
  wire        d_p      = rd_data[15];
  wire [1:0]  d_dpl    = rd_data[14:13];
  wire        d_g      = rd_data[23];
  wire [19:0] d_lim20  = {rd_data[19:16], lo_w[15:0]};
  wire [31:0] d_base   = {rd_data[31:24], rd_data[7:0], lo_w[31:16]};
  wire [31:0] d_lim    = d_g ? {d_lim20, 12'hFFF} : {12'h000, d_lim20};
  wire        d_ok     = d_p && (eff_pl <= d_dpl);

  assign busy     = (st != S_IDLE);
  assign rd_valid = (st == S_LO) || (st == S_HI);
  assign rd_addr  = TBL_BASE + {16'h0000, pend_sel[15:3], 3'b000} +
                    ((st == S_HI) ? 32'd4 : 32'd0);
  assign xl_lin   = c_base + xl_off;
  assign xl_fault = xl_valid && (!seg_valid || (xl_off > c_lim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ld_done   <= 1'b0;
      ld_fault  <= 1'b0;
      pend_sel  <= '0;
      pend_cpl  <= '0;
      lo_w      <= '0;
      seg_valid <= 1'b0;
      seg_sel   <= '0;
      seg_attr  <= '0;
      c_base    <= '0;
      c_lim     <= '0;
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;
      case (st)
        S_IDLE: if (ld_req) begin
          if (pre_bad) begin
            ld_done  <= 1'b1;
            ld_fault <= 1'b1;
          end else begin
            pend_sel <= ld_sel;
            pend_cpl <= cpl;
            st       <= S_LO;
          end
        end
        S_LO: if (rd_ready) begin
          lo_w <= rd_data;
          st   <= S_HI;
        end
        S_HI: if (rd_ready) begin
          ld_done <= 1'b1;
          st      <= S_IDLE;
          if (d_ok) begin
            seg_valid <= 1'b1;
            seg_sel   <= pend_sel;
            seg_attr  <= {rd_data[23:20], rd_data[15:8]};
            c_base    <= d_base;
            c_lim     <= d_lim;
          end else begin
            ld_fault <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/segreg_xlate_chk.sv
module segreg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ld_done,
  input logic        ld_fault,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        xl_valid,
  input logic        xl_fault,
  input logic        seg_valid,
  input logic [15:0] seg_sel
);
  // R5: a fault is always reported as the end of a load
  p_fault_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> ld_done);

  // R5: the loaded selector and validity survive a fault
  p_sel_kept_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> ($stable(seg_sel) && $stable(seg_valid)));

  // R10: memory traffic only while a load is in progress
  p_read_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R10: a stalled read keeps its request and address
  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R1: table words are fetched on 32-bit boundaries
  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));

  // R9: no translation succeeds without a loaded segment
  p_no_seg_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !seg_valid) |-> xl_fault);
endmodule

bind segreg_xlate segreg_xlate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ld_done(ld_done),
  .ld_fault(ld_fault), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .xl_valid(xl_valid), .xl_fault(xl_fault),
  .seg_valid(seg_valid), .seg_sel(seg_sel)
);

// File: tb/test_segreg_xlate.sv
module test_segreg_xlate;
  localparam int          CLK_PERIOD = 10;
  localparam int          N_ENT      = 8;
  localparam logic [31:0] T_BASE     = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0;
  logic [15:0] ld_sel = '0;
  logic [1:0]  cpl = '0;
  logic        busy, ld_done, ld_fault, rd_valid, rd_ready;
  logic [31:0] rd_addr, rd_data;
  logic        xl_valid = 1'b0;
  logic [31:0] xl_off = '0;
  logic [31:0] xl_lin;
  logic        xl_fault, seg_valid;
  logic [15:0] seg_sel;
  logic [11:0] seg_attr;

  segreg_xlate #(.TBL_ENTRIES(N_ENT), .TBL_BASE(T_BASE)) i_segreg_xlate (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_sel(ld_sel), .cpl(cpl),
    .busy(busy), .ld_done(ld_done), .ld_fault(ld_fault),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .xl_valid(xl_valid), .xl_off(xl_off),
    .xl_lin(xl_lin), .xl_fault(xl_fault), .seg_valid(seg_valid),
    .seg_sel(seg_sel), .seg_attr(seg_attr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [31:0] e_base [N_ENT];
  logic [19:0] e_lim  [N_ENT];
  logic [15:0] e_flg  [N_ENT];

  function automatic logic [31:0] word_of(input int i, input bit hi);
    if (!hi) return {e_base[i][15:0], e_lim[i][15:0]};
    return {e_base[i][31:24], e_flg[i][15:12], e_lim[i][19:16],
            e_flg[i][7:0], e_base[i][23:16]};
  endfunction

  function automatic logic [31:0] eff_lim(input int i);
    return e_flg[i][15] ? {e_lim[i], 12'hFFF} : {12'h000, e_lim[i]};
  endfunction

  logic [31:0] rel;
  assign rel     = rd_addr - T_BASE;
  assign rd_data = (rel[31:3] < N_ENT) ? word_of(int'(rel[31:3]), rel[2]) : 32'h0;

  int rdy_cnt = 0;
  always @(negedge clk) rdy_cnt <= rdy_cnt + 1;
  assign rd_ready = (rdy_cnt % 3) != 0;

  int rd_cnt = 0;
  logic [31:0] a_last = '0, a_prev = '0;
  always @(posedge clk) if (rd_valid && rd_ready) begin
    rd_cnt <= rd_cnt + 1;
    a_prev <= a_last;
    a_last <= rd_addr;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  bit          m_valid = 1'b0;
  logic [15:0] m_sel   = '0;
  logic [31:0] m_base  = '0;
  logic [31:0] m_lim   = '0;

  task automatic chk_xlate();
    xl_valid = 1'b1;
    xl_off = 32'h0; #1;
    if (!m_valid) chk(xl_fault == 1'b1, "R9 no segment", {31'b0, xl_fault}, 1);
    else begin
      chk(!xl_fault && xl_lin == m_base, "R8 offset 0", xl_lin, m_base);
      xl_off = m_lim; #1;
      chk(!xl_fault && xl_lin == m_base + m_lim, "R7 R8 at limit", xl_lin, m_base + m_lim);
      if (m_lim != 32'hFFFF_FFFF) begin
        xl_off = m_lim + 1; #1;
        chk(xl_fault == 1'b1, "R9 past limit", {31'b0, xl_fault}, 1);
      end
    end
    xl_valid = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] sel, input logic [1:0] c);
    int idx, start, w;
    bit pre, exp_f;
    logic [1:0] rpl, mx, dpl;
    idx = int'(sel[15:3]);
    rpl = sel[1:0];
    mx  = (c > rpl) ? c : rpl;
    pre = sel[2] || idx == 0 || idx >= N_ENT;
    dpl = pre ? 2'd0 : e_flg[idx][6:5];
    exp_f = pre || !e_flg[idx][7] || (mx > dpl);
    @(negedge clk);
    start = rd_cnt;
    ld_req = 1'b1; ld_sel = sel; cpl = c;
    @(negedge clk);
    ld_req = 1'b0;
    w = 0;
    while (!ld_done && w < 60) begin @(negedge clk); w++; end
    chk(ld_done == 1'b1, "R10 completion", {31'b0, ld_done}, 1);
    if (pre) begin
      chk(ld_fault == 1'b1, "R2 early fault", {31'b0, ld_fault}, 1);
      chk(rd_cnt == start, "R2 no reads", rd_cnt - start, 0);
    end else begin
      chk(rd_cnt - start == 2, "R1 two reads", rd_cnt - start, 2);
      chk(a_prev == T_BASE + 8 * idx, "R1 low word addr", a_prev, T_BASE + 8 * idx);
      chk(a_last == T_BASE + 8 * idx + 4, "R1 high word addr", a_last, T_BASE + 8 * idx + 4);
      if (!e_flg[idx][7])
        chk(ld_fault == 1'b1, "R4 not present", {31'b0, ld_fault}, 1);
      else
        chk(ld_fault == exp_f, "R3 privilege", {31'b0, ld_fault}, {31'b0, exp_f});
    end
    if (exp_f) begin
      chk(seg_sel == m_sel && seg_valid == m_valid, "R5 unchanged", {16'b0, seg_sel}, {16'b0, m_sel});
    end else begin
      m_valid = 1'b1; m_sel = sel; m_base = e_base[idx]; m_lim = eff_lim(idx);
      chk(seg_sel == sel && seg_valid, "R5 loaded selector", {16'b0, seg_sel}, {16'b0, sel});
      chk(seg_attr == {e_flg[idx][15:12], e_flg[idx][7:0]}, "R6 attributes",
          {20'b0, seg_attr}, {20'b0, e_flg[idx][15:12], e_flg[idx][7:0]});
    end
    chk_xlate();
  endtask

  initial begin
    e_base[0] = 32'h0;         e_lim[0] = 20'h0;     e_flg[0] = 16'h0000;
    e_base[1] = 32'h0;         e_lim[1] = 20'hFFFFF; e_flg[1] = 16'hC09A;
    e_base[2] = 32'h0;         e_lim[2] = 20'hFFFFF; e_flg[2] = 16'hC092;
    e_base[3] = 32'h0;         e_lim[3] = 20'hFFFFF; e_flg[3] = 16'hC0FA;
    e_base[4] = 32'h0010_0000; e_lim[4] = 20'hFFFFF; e_flg[4] = 16'hC0F2;
    e_base[5] = 32'h1234_5678; e_lim[5] = 20'h00FFF; e_flg[5] = 16'h40F2;
    e_base[6] = 32'hABCD_0000; e_lim[6] = 20'h00100; e_flg[6] = 16'h4072;
    e_base[7] = 32'h8000_0000; e_lim[7] = 20'h0000F; e_flg[7] = 16'hC0B2;

    repeat (3) @(negedge clk);
    chk(!busy && !ld_done && !ld_fault && !rd_valid, "R11 idle in reset",
        {28'b0, busy, ld_done, ld_fault, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!seg_valid && seg_sel == 16'h0, "R11 empty register", {16'b0, seg_sel}, 0);
    chk_xlate();

    // busy window: second request during fetch is dropped
    ld_req = 1'b1; ld_sel = 16'h0010; cpl = 2'd0;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy after accept", {31'b0, busy}, 1);
    ld_sel = 16'h002B;
    @(negedge clk);
    ld_req = 1'b0;
    for (int w = 0; w < 60 && !ld_done; w++) @(negedge clk);
    chk(ld_done && !ld_fault && seg_sel == 16'h0010, "R10 request while busy ignored",
        {16'b0, seg_sel}, 32'h10);
    chk(rd_cnt == 2, "R10 single fetch", rd_cnt, 2);
    m_valid = 1'b1; m_sel = 16'h0010; m_base = 32'h0; m_lim = 32'hFFFF_FFFF;
    chk_xlate();

    for (int c = 0; c < 4; c++)
      for (int i = 0; i < N_ENT + 2; i++)
        for (int ti = 0; ti < 2; ti++)
          for (int r = 0; r < 4; r++)
            do_load({i[12:0], ti[0], r[1:0]}, c[1:0]);

    // wrap-around on the ring-3 data segment with a raised base
    do_load(16'h0023, 2'd3);
    xl_valid = 1'b1; xl_off = 32'hFFFF_FFFF; #1;
    chk(!xl_fault && xl_lin == 32'h000F_FFFF, "R8 wrap", xl_lin, 32'h000F_FFFF);
    xl_valid = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule